// File: doc/BRIEF.md
# Shadow Copy Agreement Poller with Commit Writes

This block is a small bus master. It runs after software has changed a bandwidth floor or ceiling for one partition. The new setting is copied into a bank of per-slice 64-bit shadow registers, and those copies do not all update at the same moment. The block first waits until every copy agrees, and only then issues the two writes that move the shadow values into the registers that act on them. Without the wait, the writes could run ahead of the copies.

A pulse on `start_i` latches a partition number and begins a series of sweeps. Each sweep reads slice 0 as the reference value and then reads the other slices in ascending order. The sweep stops at the first value that differs from the reference. A sweep with no difference ends polling. If the failed sweeps reach a set limit, polling also ends and a sticky timeout flag is raised. In both cases the block writes zero to the first commit register and then to the second, and pulses `done_o`. The master port allows one transfer at a time. Each request is held until the responder acknowledges it, and read data is taken in the acknowledge cycle.

Top module: `shadow_sync_commit`

## Requirements
- R1: After reset, `busy_o`, `bus_req_o`, `done_o` and `timeout_o` are all 0.
- R2: Every shadow access is a read (`bus_we_o`=0) at address BASE_ADDR + 0x360048 + slice*0x10000 + partition*8, using the partition latched at start.
- R3: A sweep reads slice 0 first and then slices 1..NSLICE-1 in ascending order. The first value that differs from the slice-0 value ends the sweep, and the next read is slice 0 again.
- R4: When one sweep has all NSLICE values equal, the block writes (`bus_we_o`=1, `bus_wdata_o`=0) to BASE_ADDR+0x1b0000 and then to BASE_ADDR+0x1c0000. No write is issued before polling ends.
- R5: If MAX_SWEEPS (1000) sweeps have all failed, `timeout_o` rises in the cycle after the acknowledge of the last mismatching read. It stays high, and the two commit writes are still issued. Failing exactly MAX_SWEEPS-1 times and then succeeding does not raise it.
- R6: Only one transfer is outstanding at a time. `bus_req_o`, `bus_addr_o` and `bus_we_o` hold until `bus_ack_i` is seen with the request. `bus_req_o` is 0 whenever `busy_o` is 0.
- R7: `done_o` is high for exactly one cycle, the cycle after the acknowledge of the second commit write.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored. The partition number and the transfer sequence are unchanged.
- R9: An accepted start clears `timeout_o` from the next cycle on. It also restarts the failed-sweep count, so each run gets the full MAX_SWEEPS budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only when idle |
| pid_i | input | PID_W | Partition number, latched at start |
| bus_req_o | output | 1 | Transfer request valid |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Transfer address |
| bus_wdata_o | output | DATA_W | Write data (always zero) |
| bus_ack_i | input | 1 | Transfer accepted or completed |
| bus_rdata_i | input | DATA_W | Read data, valid with `bus_ack_i` |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Sticky: copies never agreed |

## Verification
The main function is driven with several shadow patterns, and each one separates a different fault:
- All copies agree at once. This shows the plain sweep and the write order.
- A middle slice is stale for a few sweeps. This shows the abort point and the return to slice 0.
- The last slice is stale. This catches an off-by-one at the end of a sweep.
- The reference slice itself is stale. This shows that the comparison is made against slice 0 and not against a fixed value.
- The last slice fails 999 times and then 1000 times. These two runs sit on the timeout boundary.

Randomly stalled acknowledges test the holding of requests, and extra start pulses are sent mid-run.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POLL = 2'd1,
    ST_CMT0 = 2'd2,
    ST_CMT1 = 2'd3
  } ssc_state_e;
endpackage

// File: rtl/ssc_addr_gen.sv
module ssc_addr_gen
  import ssc_pkg::*;
#(
  parameter int          ADDR_W       = 48,
  parameter int          PID_W        = 16,
  parameter int          SLICE_W      = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int unsigned SHADOW_OFF   = 32'h0036_0048,
  parameter int unsigned SLICE_STRIDE = 32'h0001_0000,
  parameter int unsigned PID_STRIDE   = 8,
  parameter int unsigned CMT0_OFF     = 32'h001b_0000,
  parameter int unsigned CMT1_OFF     = 32'h001c_0000
) (
  input  ssc_state_e         state_i,
  input  logic [SLICE_W-1:0] slice_i,
  input  logic [PID_W-1:0]   pid_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [ADDR_W-1:0] shadow_addr;

  always_comb begin
    shadow_addr = BASE_ADDR + ADDR_W'(SHADOW_OFF)
                + ADDR_W'(slice_i) * ADDR_W'(SLICE_STRIDE)
                + ADDR_W'(pid_i) * ADDR_W'(PID_STRIDE);
    case (state_i)
      ST_CMT0: addr_o = BASE_ADDR + ADDR_W'(CMT0_OFF);
      ST_CMT1: addr_o = BASE_ADDR + ADDR_W'(CMT1_OFF);
      default: addr_o = shadow_addr;
    endcase
  end
endmodule

// File: rtl/ssc_ref_cmp.sv
module ssc_ref_cmp #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              mismatch_o
);
  logic [DATA_W-1:0] ref_q;

  always_ff @(posedge clk) begin
    if (rst)            ref_q <= '0;
    else if (capture_i) ref_q <= rdata_i;
  end

  assign mismatch_o = (rdata_i != ref_q);
endmodule

// File: rtl/ssc_sweep_ctr.sv
module ssc_sweep_ctr #(
  parameter int MAX_SWEEPS = 1000,
  localparam int CNT_W = $clog2(MAX_SWEEPS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(MAX_SWEEPS - 1));
endmodule

// File: rtl/shadow_sync_commit.sv
module shadow_sync_commit
  import ssc_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int DATA_W     = 64,
  parameter int PID_W      = 16,
  parameter int NSLICE     = 12,
  parameter int MAX_SWEEPS = 1000,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  localparam int SLICE_W   = $clog2(NSLICE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [PID_W-1:0]  pid_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  ssc_state_e         state_q;
  logic [SLICE_W-1:0] slice_q;
  logic [PID_W-1:0]   pid_q;
  logic               hs;
  logic               poll_hs;
  logic               mismatch;
  logic               last_sweep;
  logic               accept;

  assign accept      = (state_q == ST_IDLE) && start_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign bus_req_o   = busy_o;
  assign bus_we_o    = (state_q == ST_CMT0) || (state_q == ST_CMT1);
  assign bus_wdata_o = '0;
  assign hs          = bus_req_o && bus_ack_i;
  assign poll_hs     = hs && (state_q == ST_POLL);

  ssc_addr_gen #(
    .ADDR_W(ADDR_W), .PID_W(PID_W), .SLICE_W(SLICE_W), .BASE_ADDR(BASE_ADDR)
  ) addr_i (
    .state_i(state_q), .slice_i(slice_q), .pid_i(pid_q), .addr_o(bus_addr_o)
  );

  ssc_ref_cmp #(.DATA_W(DATA_W)) cmp_i (
    .clk(clk), .rst(rst),
    .capture_i(poll_hs && (slice_q == '0)),
    .rdata_i(bus_rdata_i),
    .mismatch_o(mismatch)
  );

  ssc_sweep_ctr #(.MAX_SWEEPS(MAX_SWEEPS)) ctr_i (
    .clk(clk), .rst(rst),
    .clr_i(accept),
    .inc_i(poll_hs && (slice_q != '0) && mismatch),
    .last_o(last_sweep)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      slice_q   <= '0;
      pid_q     <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_POLL;
          slice_q   <= '0;
          pid_q     <= pid_i;
          timeout_o <= 1'b0;
        end
        ST_POLL: if (hs) begin
          if (slice_q == '0) begin
            slice_q <= SLICE_W'(1);
          end else if (mismatch) begin
            slice_q <= '0;
            if (last_sweep) begin
              timeout_o <= 1'b1;
              state_q   <= ST_CMT0;
            end
          end else if (slice_q == SLICE_W'(NSLICE - 1)) begin
            state_q <= ST_CMT0;
          end else begin
            slice_q <= slice_q + SLICE_W'(1);
          end
        end
        ST_CMT0: if (hs) state_q <= ST_CMT1;
        ST_CMT1: if (hs) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o
);
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !bus_req_o); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(bus_req_o && bus_ack_i && bus_we_o)); // R7
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
    timeout_o && !(start_i && !busy_o) |=> timeout_o); // R5
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_we_o) |-> $past(bus_req_o && bus_ack_i && !bus_we_o)); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    busy_o && !bus_ack_i |=> busy_o); // R8
endmodule

bind shadow_sync_commit ssc_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .bus_req_o(bus_req_o),
  .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .bus_ack_i(bus_ack_i),
  .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
);

// File: tb/shadow_sync_commit_tb_top.sv
module shadow_sync_commit_tb_top;
  localparam logic [47:0] BASE = 48'h0000_1900_0000;
  localparam int NS = 12;
  localparam int MAXS = 1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] pid_i = '0;
  logic        bus_req_o, bus_we_o, busy_o, done_o, timeout_o;
  logic [47:0] bus_addr_o;
  logic [63:0] bus_wdata_o;
  logic        bus_ack_i = 1'b0;
  logic [63:0] bus_rdata_i = '0;

  always #5 clk = ~clk;

  shadow_sync_commit #(.BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .pid_i(pid_i),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  typedef struct { logic [47:0] a; bit we; bit to; } txn_t;
  txn_t q[$];

  int checks = 0, errors = 0, cyc = 0;
  bit exp_done = 0, exp_to = 0, stall = 0;
  logic [15:0] cur_pid;
  int bad_s, bad_n, rsp_sweep;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] shval(input int s, input int sw);
    if (s == bad_s && sw <= bad_n) return 64'hBAD0_0000 + 64'(sw);
    return 64'h0123_4567_89AB_CDEF ^ 64'(cur_pid);
  endfunction

  function automatic logic [47:0] shaddr(input int s);
    return BASE + 48'h36_0048 + 48'(s) * 48'h1_0000 + 48'(cur_pid) * 48'd8;
  endfunction

  task automatic step(input bit st, input logic [15:0] spid);
    bit ack;
    logic [63:0] rd;
    @(negedge clk);
    cyc++;
    ack = 0;
    rd = '0;
    chk(done_o == exp_done, "R7 done pulse", 64'(done_o), 64'(exp_done));
    exp_done = 0;
    chk(bus_req_o == (q.size() > 0), "R6 request", 64'(bus_req_o), 64'(q.size() > 0));
    chk(busy_o == (q.size() > 0), "R8 busy", 64'(busy_o), 64'(q.size() > 0));
    chk(timeout_o == exp_to, "R5 timeout", 64'(timeout_o), 64'(exp_to));
    if (q.size() > 0 && bus_req_o) begin
      chk(bus_addr_o == q[0].a, q[0].we ? "R4 commit addr" : "R3 shadow addr", 64'(bus_addr_o), 64'(q[0].a));
      chk(bus_we_o == q[0].we, q[0].we ? "R4 write" : "R2 read", 64'(bus_we_o), 64'(q[0].we));
      if (q[0].we) chk(bus_wdata_o == '0, "R4 zero data", bus_wdata_o, 64'd0);
      ack = !(stall && ($urandom_range(0, 2) == 0));
      if (ack) begin
        if (!q[0].we) begin
          int s;
          s = int'((bus_addr_o - BASE - 48'h36_0048 - 48'(cur_pid) * 48'd8) >> 16);
          if (s == 0) rsp_sweep++;
          rd = shval(s, rsp_sweep);
        end
        if (q[0].to) exp_to = 1;
        void'(q.pop_front());
        if (q.size() == 0) exp_done = 1;
      end
    end
    bus_ack_i = ack;
    bus_rdata_i = rd;
    start_i = st;
    pid_i = spid;
  endtask

  task automatic run(input logic [15:0] pid, input int bs, input int bn, input bit stl, input bit inject);
    txn_t b[$];
    bit matched = 0;
    int n = 0;
    cur_pid = pid; bad_s = bs; bad_n = bn; stall = stl; rsp_sweep = 0;
    for (int sw = 1; sw <= MAXS && !matched; sw++) begin
      b.push_back('{shaddr(0), 1'b0, 1'b0});
      matched = 1;
      for (int s = 1; s < NS; s++) begin
        b.push_back('{shaddr(s), 1'b0, 1'b0});
        if (shval(s, sw) != shval(0, sw)) begin matched = 0; break; end
      end
    end
    if (!matched) b[b.size()-1].to = 1;
    b.push_back('{BASE + 48'h1b_0000, 1'b1, 1'b0});
    b.push_back('{BASE + 48'h1c_0000, 1'b1, 1'b0});
    step(1, pid);
    exp_to = 0;  // R9 cleared on accepted start
    q = b;
    while (q.size() > 0 && n < 20000) begin
      step(inject && n == 5, 16'h7777);  // R8 start while busy
      n++;
    end
    if (q.size() > 0) begin
      errors++;
      $display("FAIL watchdog run pid=%0h act=%0d exp=0", pid, q.size());
      q.delete();
    end
    step(0, 0);
    step(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    step(0, 0);  // R1 reset state
    chk(!busy_o && !bus_req_o && !done_o && !timeout_o, "R1 reset", 64'({busy_o, bus_req_o, done_o, timeout_o}), 64'd0);
    run(16'h0003, 99, 0, 0, 0);      // R2 R4 clean
    run(16'h0021, 5, 3, 1, 1);       // R3 middle slice stale, stalls
    run(16'hFFFF, 11, 2, 1, 0);      // R3 last slice stale
    run(16'h0040, 0, 1, 0, 0);       // R3 reference stale
    run(16'h0002, 1, 5000, 0, 1);    // R5 timeout, R8 inject
    run(16'h0009, 99, 0, 1, 1);      // R9 clears timeout
    run(16'h0011, 11, 999, 0, 0);    // R5 boundary no timeout
    run(16'h0012, 11, 1000, 0, 0);   // R5 boundary timeout, R9 fresh count
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule